// File: doc/BRIEF.md
# Prescaled 32-bit Down-Counting Timer

This block is a 32-bit timer that counts down and is driven from a register port. A programmable prescaler divides the input clock, and the count drops by one on each divided tick. The timer signals only when the count reaches zero. At that point it sets a sticky status flag. If the matching enable is set, it also raises a level-sensitive interrupt request.

Software controls the timer through five word registers:

| Index | Register |
|-------|----------|
| 0 | control |
| 1 | count |
| 2 | preload |
| 3 | status |
| 4 | interrupt enable |

Counting needs two control bits, enable and start, to be set together. A mode bit chooses what happens at zero. In the first mode the count reloads from the preload register and counting carries on. In the other mode the timer parks at zero and clears its own start bit.

Writes take effect at the clock edge. Reads are combinational from the addressed register.

Top module: `prescaled_down_timer`

## Requirements
- R1: After reset, the control, count, status and interrupt-enable registers read zero, the preload register reads 0xFFFFFFFF, and `irq` is low.
- R2: The count changes only while control bit 0 (enable) and control bit 5 (start) are both 1, or when software writes it. Otherwise it holds its value.
- R3: Control bits 31:16 hold a prescale value N. While running, the count decrements once every N+1 clocks. The first decrement after the timer starts running comes N+1 clocks later.
- R4: A prescaled tick that finds the count at 1 or 0 is a zero event.
- R5: With control bit 3 (auto-restart) set, a zero event loads the count from the preload register, and counting continues.
- R6: With auto-restart clear, a zero event sets the count to 0 and clears the start bit, so the timer stops.
- R7: A write to the count register (index 1) loads the written value and restarts the prescale divider. It overrides any tick in the same cycle, and no zero event occurs in that cycle.
- R8: Status bit 0 is set by a zero event. Writing 1 to status bit 0 (index 3) clears it. A zero event in the same cycle as that clear leaves the flag set.
- R9: `irq` is high exactly when status bit 0 and interrupt-enable bit 0 (index 4) are both 1.
- R10: Control bits other than 0, 3, 5 and 31:16, status and interrupt-enable bits other than bit 0, and unmapped indices 5 to 7 all read zero and ignore writes.
- R11: Any write to the control register restarts the prescale divider. When both the control write and a tick land in the same cycle, the written start bit wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume the bus asserts at most one write per cycle and that a write lasts one strobe cycle. They also assume that no write touches the count or control register in a cycle where they expect the count or start bit to follow the timer's own rules. Each property therefore names those writes as exclusions in its antecedent.

The stimulus drives one bus operation per clock, on the falling edge. It places count, control and status writes on purpose right beside zero events, so the priority rules come into play, while the excluded cases stay out of the properties' scope. A behavioural model in the bench follows every cycle and checks the read data and `irq` against its own state.

// File: rtl/prescaled_down_timer.sv
module prescaled_down_timer #(
  parameter int DW = 32,
  parameter int PW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTL = AW'(0);
  localparam logic [AW-1:0] A_CNT = AW'(1);
  localparam logic [AW-1:0] A_PRE = AW'(2);
  localparam logic [AW-1:0] A_STS = AW'(3);
  localparam logic [AW-1:0] A_IEN = AW'(4);
  localparam int PS_LO = DW - PW;

  logic          en_q, auto_q, start_q, sts_q, ien_q;
  logic [PW-1:0] ps_q, div_q;
  logic [DW-1:0] cnt_q, pre_q;

  wire wr_ctl   = bus_wr && bus_addr == A_CTL;
  wire wr_cnt   = bus_wr && bus_addr == A_CNT;
  wire wr_pre   = bus_wr && bus_addr == A_PRE;
  wire wr_sts   = bus_wr && bus_addr == A_STS;
  wire wr_ien   = bus_wr && bus_addr == A_IEN;
  wire run      = en_q && start_q;
  wire tick     = run && div_q == ps_q;
  wire zero_evt = tick && cnt_q <= DW'(1) && !wr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; auto_q <= 1'b0; start_q <= 1'b0;
      ps_q <= '0; div_q <= '0;
      cnt_q <= '0; pre_q <= '1;
      sts_q <= 1'b0; ien_q <= 1'b0;
    end else begin
      if (!run || tick || wr_cnt || wr_ctl) div_q <= '0;
      else                                  div_q <= div_q + PW'(1);

      if (wr_cnt)        cnt_q <= bus_wdata;
      else if (zero_evt) cnt_q <= auto_q ? pre_q : '0;
      else if (tick)     cnt_q <= cnt_q - DW'(1);

      if (wr_ctl) begin
        en_q    <= bus_wdata[0];
        auto_q  <= bus_wdata[3];
        start_q <= bus_wdata[5];
        ps_q    <= bus_wdata[DW-1:PS_LO];
      end else if (zero_evt && !auto_q) begin
        start_q <= 1'b0;
      end

      if (wr_pre) pre_q <= bus_wdata;
      if (wr_ien) ien_q <= bus_wdata[0];

      if (zero_evt)                      sts_q <= 1'b1;
      else if (wr_sts && bus_wdata[0])   sts_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTL: begin
        bus_rdata[0] = en_q;
        bus_rdata[3] = auto_q;
        bus_rdata[5] = start_q;
        bus_rdata[DW-1:PS_LO] = ps_q;
      end
      A_CNT: bus_rdata = cnt_q;
      A_PRE: bus_rdata = pre_q;
      A_STS: bus_rdata[0] = sts_q;
      A_IEN: bus_rdata[0] = ien_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = sts_q & ien_q;

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(cnt_q));
  // R3
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q > DW'(1) && !wr_cnt) |=> cnt_q == $past(cnt_q) - DW'(1));
  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && auto_q) |=> cnt_q == $past(pre_q));
  // R6
  stop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && !auto_q && !wr_ctl) |=> (!start_q && cnt_q == '0));
  // R8
  sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && !(wr_sts && bus_wdata[0])) |=> sts_q);
  // R8
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> sts_q);
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (ien_q && sts_q));
endmodule

// File: tb/prescaled_down_timer_tb.sv
`timescale 1ns/1ps
module prescaled_down_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  bit          m_en, m_auto, m_start, m_sts, m_ien;
  int unsigned m_ps, m_div;
  logic [31:0] m_cnt, m_pre;

  always #2.5 clk = ~clk;

  prescaled_down_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [31:0] model_read(input logic [2:0] a);
    logic [31:0] v = '0;
    case (a)
      3'd0: v = {m_ps[15:0], 10'd0, m_start, 1'b0, m_auto, 2'b00, m_en};
      3'd1: v = m_cnt;
      3'd2: v = m_pre;
      3'd3: v = {31'd0, m_sts};
      3'd4: v = {31'd0, m_ien};
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic model_reset();
    m_en = 0; m_auto = 0; m_start = 0; m_sts = 0; m_ien = 0;
    m_ps = 0; m_div = 0; m_cnt = 0; m_pre = 32'hFFFF_FFFF;
  endtask

  task automatic model_step(input bit wr, input logic [2:0] a, input logic [31:0] d);
    bit running = m_en && m_start;
    bit tk = running && (m_div == m_ps);
    bit cw = wr && a == 3'd1;
    bit ctw = wr && a == 3'd0;
    bit hit = tk && (m_cnt == 0 || m_cnt == 1) && !cw;
    bit old_auto = m_auto;
    logic [31:0] old_pre = m_pre;
    if (!running || tk || cw || ctw) m_div = 0; else m_div++;
    if (cw) m_cnt = d;
    else if (hit) m_cnt = old_auto ? old_pre : 32'd0;
    else if (tk) m_cnt = m_cnt - 1;
    if (ctw) begin
      m_en = d[0]; m_auto = d[3]; m_start = d[5]; m_ps = d[31:16];
    end else if (hit && !old_auto) m_start = 0;
    if (wr && a == 3'd2) m_pre = d;
    if (wr && a == 3'd4) m_ien = d[0];
    if (hit) m_sts = 1;
    else if (wr && a == 3'd3 && d[0]) m_sts = 0;
  endtask

  task automatic compare();
    logic [31:0] exp_rd = model_read(bus_addr);
    bit exp_irq = m_sts && m_ien;
    checks++;
    if (bus_rdata !== exp_rd) begin
      errors++;
      $display("FAIL %s rdata addr %0d actual %h expected %h", cur_req, bus_addr, bus_rdata, exp_rd);
    end
    checks++;
    if (irq !== exp_irq) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b", cur_req, irq, exp_irq);
    end
  endtask

  task automatic op(input bit wr, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    compare();
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_step(wr, a, d);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    op(1'b1, a, d);
  endtask

  task automatic idle(input int n, input logic [2:0] a);
    for (int i = 0; i < n; i++) op(1'b0, a, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    for (int a = 0; a < 8; a++) op(1'b0, 3'(a), '0);

    cur_req = "R10";
    wr_reg(3'd0, 32'h0000_FFD6);
    idle(2, 3'd0);
    wr_reg(3'd3, 32'hFFFF_FFFE);
    wr_reg(3'd4, 32'hFFFF_FFFE);
    wr_reg(3'd6, 32'hFFFF_FFFF);
    for (int a = 0; a < 8; a++) op(1'b0, 3'(a), '0);
    wr_reg(3'd0, 32'h0);

    cur_req = "R2";
    wr_reg(3'd1, 32'd9);
    wr_reg(3'd0, 32'h0000_0001);
    idle(6, 3'd1);
    wr_reg(3'd0, 32'h0000_0020);
    idle(6, 3'd1);

    cur_req = "R3";
    wr_reg(3'd0, 32'h0002_0021);
    idle(12, 3'd1);

    cur_req = "R6";
    idle(14, 3'd1);
    idle(3, 3'd0);
    cur_req = "R8";
    idle(2, 3'd3);
    cur_req = "R9";
    wr_reg(3'd4, 32'h1);
    idle(2, 3'd3);
    cur_req = "R8";
    wr_reg(3'd3, 32'h1);
    idle(2, 3'd3);

    cur_req = "R5";
    wr_reg(3'd2, 32'd3);
    wr_reg(3'd1, 32'd2);
    wr_reg(3'd0, 32'h0000_0029);
    idle(12, 3'd1);
    cur_req = "R8";
    for (int k = 0; k < 8; k++) begin
      wr_reg(3'd3, 32'h1);
      idle(1, 3'd3);
    end

    cur_req = "R7";
    wr_reg(3'd0, 32'h0001_0029);
    for (int k = 0; k < 6; k++) begin
      idle(k % 3, 3'd1);
      wr_reg(3'd1, 32'd2);
      idle(2, 3'd1);
    end
    wr_reg(3'd1, 32'd0);
    idle(4, 3'd1);

    cur_req = "R11";
    wr_reg(3'd0, 32'h0003_0029);
    for (int k = 0; k < 5; k++) begin
      idle(k, 3'd1);
      wr_reg(3'd0, 32'h0003_0029);
    end
    idle(10, 3'd1);
    wr_reg(3'd1, 32'd1);
    idle(3, 3'd1);
    wr_reg(3'd0, 32'h0000_0029);

    cur_req = "R4";
    wr_reg(3'd0, 32'h0000_0021);
    wr_reg(3'd1, 32'd0);
    idle(3, 3'd0);
    idle(2, 3'd1);

    cur_req = "R1";
    @(negedge clk);
    rst_n = 1'b0;
    bus_wr = 1'b0;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 5; a++) op(1'b0, 3'(a), '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule